// File: doc/BRIEF.md
# Dual-Channel Timer/Counter

This block holds two up-counting timer/counter channels that share one configuration register. Each channel advances on an internal tick, derived by dividing the system clock by a fixed prescale factor (twelve by default), or on falling edges seen on its own external count pin. A channel counts only while its run input is high. The configuration register gives each channel its own count mode and its own tick source.

Each channel has two count modes. The first is a 16-bit free-running count formed from a high byte and a low byte. The second is an 8-bit auto-reload count, in which the low byte counts and the high byte holds the reload value. When a channel rolls over, it sets a sticky overflow flag and raises a one-clock overflow strobe. The strobe can drive downstream logic such as a baud-rate generator.

Software-side logic writes the configuration register and the four count bytes through a simple write port. It clears each flag with a dedicated input.

Top module: `duo_tc`

## Requirements
- R1: After a synchronous reset, every count byte is 0x00, both flags and both strobes are low, and the configuration is all zeros, so both channels hold.
- R2: A channel changes its count only while its run bit is 1. With run at 0, the count stays frozen indefinitely.
- R3: Configuration bits [3:0] set up channel 0 and bits [7:4] set up channel 1, independently of each other. In each nibble, bits [1:0] select the mode: 01 is 16-bit and 10 is 8-bit auto-reload. A channel whose nibble has 00 or 11 in bits [1:0] holds its count. Nibble bit 3 is ignored.
- R4: When nibble bit 2 is 0, a running channel advances exactly once per PRESCALE clocks (PRESCALE = 12).
- R5: In 16-bit mode, the low byte advances on each step and the high byte advances when the low byte wraps from 0xFF to 0x00. A step from 0xFFFF gives 0x0000 and sets the flag.
- R6: In auto-reload mode, only the low byte advances. A step from 0xFF loads the low byte from the high byte, leaves the high byte unchanged and sets the flag, so a high byte of 256−N gives one overflow every N steps.
- R7: When nibble bit 2 is 1, the channel's count pin passes through a two-flop synchronizer. The synchronized level is sampled on each internal tick. One step occurs for each tick sample that reads low directly after a sample that read high. A pin held at a constant level gives no steps.
- R8: An overflow flag stays set until its clear input is pulsed. If an overflow and a clear coincide, the flag ends up set.
- R9: Each overflow produces a strobe that is high for exactly one clock, on the same edge that sets the flag.
- R10: The write addresses are: 0 for configuration, 1 for channel 0 low byte, 2 for channel 0 high byte, 3 for channel 1 low byte and 4 for channel 1 high byte. A byte write in the same clock as a step of that channel takes effect, and that step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register select (see R10) |
| wr_data | input | 8 | Write data |
| run | input | 2 | Per-channel run enable |
| flag_clr | input | 2 | Per-channel overflow flag clear |
| ext_pin | input | 2 | Per-channel external count pin |
| count_q | output | 32 | Channel c count {high, low} at bits [16c+15:16c] |
| ovf_flag | output | 2 | Sticky overflow flags |
| ovf_pulse | output | 2 | One-clock overflow strobes |

## Verification
The bench targets the carry from low byte to high byte and the full 16-bit wrap. A design that got these wrong would show 0x0100 missing, or would leave the flag clear at 0xFFFF. In auto-reload mode, the bench checks that the reload takes the high-byte value and that overflows recur at the programmed period; an off-by-one design would drift from one strobe per N ticks. For external counting, the bench checks that a steady pin gives no count and that each falling edge gives exactly one count; a level-sensitive design would count on every tick. The bench also aligns a byte write and an overflow clear to the exact tick clock. A design that let the step win would leave the written value off by one, and a design that let the clear win would lose an overflow.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    TM_HOLD_A  = 2'b00,
    TM_FULL16  = 2'b01,
    TM_RELOAD8 = 2'b10,
    TM_HOLD_B  = 2'b11
  } tc_mode_e;

  typedef struct packed {
    logic     ext_src;
    tc_mode_e mode;
  } tc_cfg_t;
endpackage

// File: rtl/tc_prescale.sv
module tc_prescale #(
  parameter int PRESCALE = 12,
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)                            div_q <= '0;
    else if (div_q == CW'(PRESCALE-1))  div_q <= '0;
    else                                div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == CW'(PRESCALE-1));

  // R4: ticks are never back to back
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic tick,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   level;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  assign level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst)       last_q <= 1'b1;
    else if (tick) last_q <= level;
  end

  assign fall = tick && last_q && !level;

  // R7: one detected edge never repeats on the following clock
  p_fall_single_r7: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/tc_channel.sv
module tc_channel
  import tc_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2*BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  tc_cfg_t           cfg,
  input  logic              tick,
  input  logic              ext_fall,
  input  logic              run,
  input  logic              clr,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count_q,
  output logic              flag_q,
  output logic              pulse_q
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic active, step, wrap8, wrap16, ovf;

  always_comb begin
    active = (cfg.mode == TM_FULL16) || (cfg.mode == TM_RELOAD8);
    step   = run && active && (cfg.ext_src ? ext_fall : tick) && !wr_lo && !wr_hi;
    wrap8  = &lo_q;
    wrap16 = wrap8 && (&hi_q);
    ovf    = step && ((cfg.mode == TM_FULL16) ? wrap16 : wrap8);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      hi_q    <= '0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (wr_lo)
        lo_q <= wr_data;
      else if (step)
        lo_q <= (cfg.mode == TM_RELOAD8 && wrap8) ? hi_q : lo_q + 1'b1;

      if (wr_hi)
        hi_q <= wr_data;
      else if (step && cfg.mode == TM_FULL16 && wrap8)
        hi_q <= hi_q + 1'b1;

      if (ovf)      flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;

      pulse_q <= ovf;
    end
  end

  assign count_q = {hi_q, lo_q};

  // R2: stopped and unwritten means frozen
  p_freeze_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_lo && !wr_hi) |=> $stable(count_q));
  // R6: reload mode never alters the high byte on its own
  p_reload_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == TM_RELOAD8 && !wr_hi) |=> $stable(hi_q));
  // R8: flag persists without a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  // R9: strobe comes with the flag
  p_pulse_flag_r9: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> flag_q);
  // R10: written byte lands unaltered
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (lo_q == $past(wr_data)));
endmodule

// File: rtl/duo_tc.sv
module duo_tc
  import tc_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int BYTE_W      = 8,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = $clog2(2*NCH+1),
  localparam int CNT_W  = 2*BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [NCH-1:0]     run,
  input  logic [NCH-1:0]     flag_clr,
  input  logic [NCH-1:0]     ext_pin,
  output logic [NCH*CNT_W-1:0] count_q,
  output logic [NCH-1:0]     ovf_flag,
  output logic [NCH-1:0]     ovf_pulse
);
  logic tick;
  logic cfg_wr;

  assign cfg_wr = wr_en && (wr_addr == '0);

  tc_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tc_cfg_t cfg_q;
    logic    fall, wr_lo, wr_hi;

    always_ff @(posedge clk) begin
      if (rst)         cfg_q <= '0;
      else if (cfg_wr) cfg_q <= tc_cfg_t'(wr_data[4*c +: 3]);
    end

    assign wr_lo = wr_en && (wr_addr == ADDR_W'(2*c+1));
    assign wr_hi = wr_en && (wr_addr == ADDR_W'(2*c+2));

    tc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk (clk),
      .rst (rst),
      .pin (ext_pin[c]),
      .tick(tick),
      .fall(fall)
    );

    tc_channel #(.BYTE_W(BYTE_W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .cfg     (cfg_q),
      .tick    (tick),
      .ext_fall(fall),
      .run     (run[c]),
      .clr     (flag_clr[c]),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wr_data (wr_data),
      .count_q (count_q[c*CNT_W +: CNT_W]),
      .flag_q  (ovf_flag[c]),
      .pulse_q (ovf_pulse[c])
    );
  end
endmodule

// File: tb/sim_duo_tc.sv
`timescale 1ns/1ps
module sim_duo_tc;
  localparam int PS = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  run = '0;
  logic [1:0]  flag_clr = '0;
  logic [1:0]  ext_pin = 2'b11;
  logic [31:0] count_q;
  logic [1:0]  ovf_flag, ovf_pulse;

  always #2.5 clk = ~clk;

  duo_tc u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .flag_clr(flag_clr), .ext_pin(ext_pin),
    .count_q(count_q), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  typedef struct {
    int          kind;   // 0 count, 1 flag, 2 strobe total
    int          ch;
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  int   pulses [2];
  bit   done  = 0;

  always @(posedge clk) begin
    if (rst) cyc <= 0; else cyc <= cyc + 1;
  end

  // monitor: counts strobes, pops and compares expectations
  always @(posedge clk) begin
    #1;
    if (rst) begin
      pulses[0] = 0; pulses[1] = 0;
    end else begin
      for (int c = 0; c < 2; c++) if (ovf_pulse[c]) pulses[c]++;
    end
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [15:0] act;
      e = exp_q.pop_front();
      case (e.kind)
        0:       act = count_q[e.ch*16 +: 16];
        1:       act = {15'd0, ovf_flag[e.ch]};
        default: act = 16'(pulses[e.ch]);
      endcase
      n_cmp++;
      if (act !== e.val) begin
        n_bad++;
        $display("FAIL %s ch%0d kind%0d: actual %0h expected %0h", e.tag, e.ch, e.kind, act, e.val);
      end
    end
  end

  task automatic push(input int kind, input int ch, input logic [15:0] val, input string tag);
    exp_t e;
    @(negedge clk);
    e.kind = kind; e.ch = ch; e.val = val; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_ticks(input logic [1:0] mask, input int k);
    @(negedge clk);
    run = mask;
    repeat (PS*k) @(negedge clk);
    run = 2'b00;
  endtask

  task automatic clear_flag(input int ch);
    @(negedge clk);
    flag_clr[ch] = 1'b1;
    @(negedge clk);
    flag_clr = '0;
  endtask

  task automatic align_tick();
    @(negedge clk);
    while (cyc % PS != PS-1) @(negedge clk);
  endtask

  task automatic pin_cycle(input int hold);
    @(negedge clk);
    ext_pin[1] = 1'b0;
    repeat (hold) @(negedge clk);
    ext_pin[1] = 1'b1;
    repeat (hold) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    push(0, 0, 16'h0000, "R1"); push(0, 1, 16'h0000, "R1");
    push(1, 0, 16'h0000, "R1"); push(1, 1, 16'h0000, "R1");
    push(2, 0, 16'h0000, "R1"); push(2, 1, 16'h0000, "R1");

    // R2/R4: 16-bit internal, 5 ticks on channel 0 only
    wr(3'd0, 8'h11);
    wr(3'd1, 8'h10); wr(3'd2, 8'h00);
    run_ticks(2'b01, 5);
    push(0, 0, 16'h0015, "R4");
    push(0, 1, 16'h0000, "R2");
    repeat (36) @(negedge clk);
    push(0, 0, 16'h0015, "R2");

    // R5 carry and wrap
    wr(3'd1, 8'hFE); wr(3'd2, 8'h00);
    run_ticks(2'b01, 3);
    push(0, 0, 16'h0101, "R5");
    wr(3'd1, 8'hFE); wr(3'd2, 8'hFF);
    run_ticks(2'b01, 3);
    push(0, 0, 16'h0001, "R5");
    push(1, 0, 16'h0001, "R5");
    push(2, 0, 16'h0001, "R9");
    repeat (24) @(negedge clk);
    push(1, 0, 16'h0001, "R8");
    clear_flag(0);
    push(1, 0, 16'h0000, "R8");

    // R6 auto-reload, period 5
    wr(3'd0, 8'h22);
    wr(3'd3, 8'hFB); wr(3'd4, 8'hFB);
    run_ticks(2'b10, 4);
    push(0, 1, 16'hFBFF, "R6");
    push(1, 1, 16'h0000, "R6");
    run_ticks(2'b10, 1);
    push(0, 1, 16'hFBFB, "R6");
    push(1, 1, 16'h0001, "R6");
    push(2, 1, 16'h0001, "R9");
    run_ticks(2'b10, 10);
    push(0, 1, 16'hFBFB, "R6");
    push(2, 1, 16'h0003, "R6");

    // R3 per-nibble modes
    wr(3'd0, 8'h21);
    wr(3'd1, 8'hFF); wr(3'd2, 8'h00);
    wr(3'd3, 8'hFF); wr(3'd4, 8'h80);
    run_ticks(2'b11, 1);
    push(0, 0, 16'h0100, "R3");
    push(0, 1, 16'h8080, "R3");
    push(2, 1, 16'h0004, "R3");

    // R7 external edges, channel 0 in hold mode
    wr(3'd0, 8'h60);
    wr(3'd3, 8'hFD); wr(3'd4, 8'hFD);
    clear_flag(1);
    @(negedge clk);
    run = 2'b11;
    repeat (48) @(negedge clk);
    push(0, 1, 16'hFDFD, "R7");
    push(0, 0, 16'h0100, "R3");
    pin_cycle(36);
    pin_cycle(36);
    push(0, 1, 16'hFDFF, "R7");
    pin_cycle(36);
    push(0, 1, 16'hFDFD, "R7");
    push(1, 1, 16'h0001, "R7");
    push(2, 1, 16'h0005, "R9");
    push(0, 0, 16'h0100, "R3");
    @(negedge clk);
    run = 2'b00;

    // R8 overflow and clear in the same clock
    wr(3'd0, 8'h01);
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
    align_tick();
    run = 2'b01; flag_clr = 2'b01;
    @(negedge clk);
    run = 2'b00; flag_clr = 2'b00;
    push(0, 0, 16'h0000, "R5");
    push(1, 0, 16'h0001, "R8");
    push(2, 0, 16'h0002, "R9");

    // R10 write against a step
    wr(3'd1, 8'h40); wr(3'd2, 8'h00);
    align_tick();
    run = 2'b01; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h80;
    @(negedge clk);
    run = 2'b00; wr_en = 1'b0;
    push(0, 0, 16'h0080, "R10");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule